// File: doc/BRIEF.md
# Multiplexed Local Bus Master Sequencer

This block sequences bus transactions for a core on a multiplexed address/data local bus. The core presents one request at a time on a valid/ready interface. A request carries an operation code, an address, a word count, one byte-enable pattern per word and the write data. The sequencer opens every transaction with one address state. It then runs one data state per word, and a data state is stretched by wait states until the ready input is sampled high. It drives the address strobe, the write/read indication, the transceiver direction, the active-low data enable, the byte enables and the drive for the shared lock line.

Read-modify-write requests have special handling. The sequencer first waits until no other agent holds the lock line. It then runs a locked single-word read, followed at once by a single-word write to the same address. Interrupt-acknowledge cycles hold the lock for their whole length. In a multi-word burst, the byte enables move one state ahead of the data. The address state shows the first word's pattern, and each data state shows the pattern of the word that follows it.

The sequencer checks every byte-enable pattern the request uses. An empty pattern or a pattern with a gap is refused with a one-cycle error pulse, and no bus cycle starts.

Top module: `lbus_seq`

## Requirements
- R1: Each accepted transaction begins with exactly one address state, in which `as_n` is low. The next cycle is a data state. `as_n` is high in every other cycle.
- R2: A data state in which `rdy_i` is low is followed by a wait state for the same word, with `as_n` high and `den_n` low. A word completes only in a cycle where `rdy_i` is high.
- R3: `wr_o` is 1 for a write and 0 for a read or interrupt acknowledge. It is set in the address state and holds unchanged through all of the transaction's data and wait states.
- R4: `dir_tx` is 0 in the address and data states of reads, interrupt acknowledges and the read half of a read-modify-write. It is 1 in those states of writes. It never changes between two consecutive cycles that both have `den_n` low.
- R5: `den_n` is low in every data and wait state. It is high in address, idle and lock-wait cycles.
- R6: When a read-modify-write (op 2) is accepted while `lock_busy` is high, no address state starts and `lock_drv` stays 0 until `lock_busy` is sampled low.
- R7: In a read-modify-write, `lock_drv` is 1 from the read's address state through its data states. It drops to 0 in the address state of the write that follows at once. That write uses the same address, data word 0 and byte-enable word 0. The request's word count is ignored, and each half is one word.
- R8: In an interrupt acknowledge (op 3), `lock_drv` is 1 from the address state through the final data state, and it is 0 after the transaction.
- R9: `be_o` bit i selects `lad` bits 8i+7:8i. In the address state, `be_o` shows word 0's pattern. In the data state of word k, it shows the pattern of word k+1, or of word k if k is the last word. `be_o` is constant across wait states and is 0 in idle.
- R10: The byte-enable pattern of each used word (word 0 up to `req_last`) must be non-zero with all set bits adjacent. Word k sits at `req_be[k*BE_W +: BE_W]`. A request that breaks this is consumed, `req_err` pulses for one cycle, and no bus cycle starts. Patterns of unused words are ignored.
- R11: `req_ready` is high in idle, and in the final data state of a transaction when `rdy_i` is high. If a request is taken in that final state, the next cycle is its address state; otherwise the block goes idle.
- R12: In a read data state with `rdy_i` high, `rd_valid` is 1 and `rd_data` equals `lad_in`.
- R13: `lad_oe` is 1 and `lad_out` shows the address in address states. In write data states, `lad_out` shows word k of `req_wdata` (`[k*DATA_W +: DATA_W]`). Op codes are 0 read, 1 write, 2 read-modify-write, 3 interrupt acknowledge. `req_last` gives the word count minus one, for reads and writes only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle if valid |
| req_op | input | 2 | Operation code |
| req_addr | input | DATA_W | Transaction address |
| req_last | input | CNT_W | Index of the last word of a read or write |
| req_be | input | MAX_WORDS*BE_W | Byte-enable pattern per word |
| req_wdata | input | MAX_WORDS*DATA_W | Write data per word |
| req_err | output | 1 | Illegal byte-enable pattern refused |
| rd_valid | output | 1 | Read word returned this cycle |
| rd_data | output | DATA_W | Returned read word |
| lad_out | output | DATA_W | Bus address/data out |
| lad_oe | output | 1 | Bus address/data output enable |
| lad_in | input | DATA_W | Bus address/data in |
| as_n | output | 1 | Address strobe, active low |
| wr_o | output | 1 | Write (1) or read (0) |
| dir_tx | output | 1 | Transceiver direction, 1 transmit |
| den_n | output | 1 | Data enable, active low |
| be_o | output | BE_W | Byte enables, active high |
| rdy_i | input | 1 | Ready from the addressed agent |
| lock_drv | output | 1 | Pull the shared lock line asserted |
| lock_busy | input | 1 | Lock line held by another agent |

## Verification
The checker watches several rules on every cycle. It checks that the address strobe lasts one cycle and is followed by a data state, that strobe and data enable never overlap, and that a wait state never reopens an address state. It checks that write/read and direction stay put while data enable is low, that byte enables stay frozen across wait states, that lock rises only in an address state, and that a refusal never coincides with bus activity. Other behaviours can only be shown by the directed scenarios: the exact byte-enable lookahead values in a burst, the lock-wait stall, the lock drop at the write half of a read-modify-write, the returned read data, and the refusal of illegal patterns while unused words are ignored. The same holds for going straight from a final ready into the next address state.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_RMW   = 2'd2,
      OP_IACK  = 2'd3
   } lbus_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LWAIT = 2'd1,
      ST_ADDR  = 2'd2,
      ST_DATA  = 2'd3
   } lbus_state_e;

   // True when the low 'width' bits hold one unbroken, non-empty run of ones.
   function automatic logic be_contig(input logic [63:0] pat, input int unsigned width);
      int unsigned runs;
      logic        prev;
      runs = 0;
      prev = 1'b0;
      for (int i = 0; i < 64; i++) begin
         if (i < int'(width)) begin
            if (pat[i] && !prev) runs++;
            prev = pat[i];
         end
      end
      return (runs == 1);
   endfunction

endpackage

// File: rtl/lbus_be_check.sv
module lbus_be_check
   import lbus_pkg::*;
#(
   parameter int BE_W  = 4,
   parameter int WORDS = 4,
   parameter int CNT_W = 2
) (
   input  logic [WORDS*BE_W-1:0] be_flat,
   input  logic [CNT_W-1:0]      last_i,
   output logic                  ok_o
);

   logic [WORDS-1:0] word_ok;

   for (genvar k = 0; k < WORDS; k++) begin : g_word
      assign word_ok[k] = be_contig(64'(be_flat[k*BE_W +: BE_W]), BE_W)
                          || (CNT_W'(k) > last_i);
   end

   assign ok_o = &word_ok;

endmodule

// File: rtl/lbus_word_sel.sv
module lbus_word_sel #(
   parameter int W     = 32,
   parameter int WORDS = 4,
   parameter int CNT_W = 2
) (
   input  logic [WORDS*W-1:0] flat_i,
   input  logic [CNT_W-1:0]   idx_i,
   output logic [W-1:0]       word_o
);

   always_comb begin
      word_o = '0;
      for (int k = 0; k < WORDS; k++) begin
         if (idx_i == CNT_W'(k)) word_o = flat_i[k*W +: W];
      end
   end

endmodule

// File: rtl/lbus_seq.sv
module lbus_seq
   import lbus_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int MAX_WORDS = 4,
   localparam int BE_W     = DATA_W / 8,
   localparam int CNT_W    = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   output logic                        req_ready,
   input  logic [1:0]                  req_op,
   input  logic [DATA_W-1:0]           req_addr,
   input  logic [CNT_W-1:0]            req_last,
   input  logic [MAX_WORDS*BE_W-1:0]   req_be,
   input  logic [MAX_WORDS*DATA_W-1:0] req_wdata,
   output logic                        req_err,
   output logic                        rd_valid,
   output logic [DATA_W-1:0]           rd_data,
   output logic [DATA_W-1:0]           lad_out,
   output logic                        lad_oe,
   input  logic [DATA_W-1:0]           lad_in,
   output logic                        as_n,
   output logic                        wr_o,
   output logic                        dir_tx,
   output logic                        den_n,
   output logic [BE_W-1:0]             be_o,
   input  logic                        rdy_i,
   output logic                        lock_drv,
   input  logic                        lock_busy
);

   // Elaboration-time parameter checks
   if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_width
      $error("lbus_seq: DATA_W must be a non-zero multiple of 8");
   end
   if (BE_W > 64) begin : g_bad_lanes
      $error("lbus_seq: at most 64 byte lanes are supported");
   end
   if (MAX_WORDS < 1) begin : g_bad_words
      $error("lbus_seq: MAX_WORDS must be at least 1");
   end

   lbus_state_e                 state_q;
   lbus_op_e                    op_q;
   logic [CNT_W-1:0]            last_q;
   logic [CNT_W-1:0]            beat_q;
   logic                        wr_q;
   logic                        lock_q;
   logic                        second_q;
   logic                        err_q;
   logic [DATA_W-1:0]           addr_q;
   logic [MAX_WORDS*BE_W-1:0]   be_q;
   logic [MAX_WORDS*DATA_W-1:0] wd_q;

   lbus_op_e         new_op;
   logic [CNT_W-1:0] new_last;
   logic             be_ok;
   logic             final_beat;
   logic             chain_rmw;
   logic             done_now;
   logic             take;
   logic             accept;
   logic             reject;
   logic [CNT_W-1:0] be_idx;
   logic [BE_W-1:0]  be_sel;
   logic [DATA_W-1:0] wd_sel;

   assign new_op   = lbus_op_e'(req_op);
   assign new_last = (new_op == OP_READ || new_op == OP_WRITE) ? req_last : '0;

   lbus_be_check #(
      .BE_W  (BE_W),
      .WORDS (MAX_WORDS),
      .CNT_W (CNT_W)
   ) be_chk_i (
      .be_flat (req_be),
      .last_i  (new_last),
      .ok_o    (be_ok)
   );

   assign final_beat = (beat_q == last_q);
   assign chain_rmw  = (op_q == OP_RMW) && !second_q;
   assign done_now   = (state_q == ST_DATA) && rdy_i && final_beat && !chain_rmw;
   assign req_ready  = (state_q == ST_IDLE) || done_now;
   assign take       = req_valid && req_ready;
   assign accept     = take && be_ok;
   assign reject     = take && !be_ok;

   // Byte enables run one word ahead of the data inside a burst
   assign be_idx = (state_q == ST_DATA && !final_beat) ? CNT_W'(beat_q + 1'b1) : beat_q;

   lbus_word_sel #(
      .W     (BE_W),
      .WORDS (MAX_WORDS),
      .CNT_W (CNT_W)
   ) be_sel_i (
      .flat_i (be_q),
      .idx_i  (be_idx),
      .word_o (be_sel)
   );

   lbus_word_sel #(
      .W     (DATA_W),
      .WORDS (MAX_WORDS),
      .CNT_W (CNT_W)
   ) wd_sel_i (
      .flat_i (wd_q),
      .idx_i  (beat_q),
      .word_o (wd_sel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         op_q     <= OP_READ;
         last_q   <= '0;
         beat_q   <= '0;
         wr_q     <= 1'b0;
         lock_q   <= 1'b0;
         second_q <= 1'b0;
         err_q    <= 1'b0;
         addr_q   <= '0;
         be_q     <= '0;
         wd_q     <= '0;
      end else begin
         err_q <= reject;
         if (accept) begin
            op_q     <= new_op;
            last_q   <= new_last;
            beat_q   <= '0;
            second_q <= 1'b0;
            wr_q     <= (new_op == OP_WRITE);
            addr_q   <= req_addr;
            be_q     <= req_be;
            wd_q     <= req_wdata;
            if (new_op == OP_RMW && lock_busy) begin
               state_q <= ST_LWAIT;
               lock_q  <= 1'b0;
            end else begin
               state_q <= ST_ADDR;
               lock_q  <= (new_op == OP_RMW) || (new_op == OP_IACK);
            end
         end else begin
            unique case (state_q)
               ST_IDLE: ;
               ST_LWAIT: begin
                  if (!lock_busy) begin
                     state_q <= ST_ADDR;
                     lock_q  <= 1'b1;
                  end
               end
               ST_ADDR: state_q <= ST_DATA;
               ST_DATA: begin
                  if (rdy_i) begin
                     if (!final_beat) begin
                        beat_q <= CNT_W'(beat_q + 1'b1);
                     end else if (chain_rmw) begin
                        state_q  <= ST_ADDR;
                        second_q <= 1'b1;
                        wr_q     <= 1'b1;
                        lock_q   <= 1'b0;
                        beat_q   <= '0;
                     end else begin
                        state_q <= ST_IDLE;
                        lock_q  <= 1'b0;
                     end
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign as_n     = (state_q != ST_ADDR);
   assign den_n    = (state_q != ST_DATA);
   assign wr_o     = wr_q;
   assign dir_tx   = wr_q;
   assign lock_drv = lock_q;
   assign req_err  = err_q;
   assign be_o     = (state_q == ST_ADDR || state_q == ST_DATA) ? be_sel : '0;
   assign lad_oe   = (state_q == ST_ADDR) || (state_q == ST_DATA && wr_q);
   assign lad_out  = (state_q == ST_ADDR) ? addr_q
                   : (state_q == ST_DATA && wr_q) ? wd_sel : '0;
   assign rd_valid = (state_q == ST_DATA) && !wr_q && rdy_i;
   assign rd_data  = lad_in;

endmodule

// File: rtl/lbus_seq_chk.sv
module lbus_seq_chk #(
   parameter int BE_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            as_n,
   input logic            den_n,
   input logic            wr_o,
   input logic            dir_tx,
   input logic [BE_W-1:0] be_o,
   input logic            rdy_i,
   input logic            lock_drv,
   input logic            req_err
);

   // R1
   addr_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !as_n |=> (as_n && !den_n));

   // R5
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (as_n || den_n));

   // R2
   wait_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!den_n && !rdy_i) |=> (as_n && !den_n));

   // R3
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !den_n |-> $stable(wr_o));

   // R4
   dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!den_n && $past(!den_n)) |-> $stable(dir_tx));

   // R9
   be_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!den_n && $past(!den_n) && !$past(rdy_i)) |-> $stable(be_o));

   // R9
   be_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !as_n |-> (be_o != '0));

   // R7
   lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_drv) |-> !as_n);

   // R10
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> (as_n && den_n));

endmodule

bind lbus_seq lbus_seq_chk #(.BE_W(BE_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .as_n     (as_n),
   .den_n    (den_n),
   .wr_o     (wr_o),
   .dir_tx   (dir_tx),
   .be_o     (be_o),
   .rdy_i    (rdy_i),
   .lock_drv (lock_drv),
   .req_err  (req_err)
);

// File: tb/lbus_seq_tb_top.sv
module lbus_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int NW = 4;
   localparam int BW = DW / 8;
   localparam int CW = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           req_valid = 1'b0;
   logic           req_ready;
   logic [1:0]     req_op = '0;
   logic [DW-1:0]  req_addr = '0;
   logic [CW-1:0]  req_last = '0;
   logic [NW*BW-1:0] req_be = '0;
   logic [NW*DW-1:0] req_wdata = '0;
   logic           req_err;
   logic           rd_valid;
   logic [DW-1:0]  rd_data;
   logic [DW-1:0]  lad_out;
   logic           lad_oe;
   logic [DW-1:0]  lad_in = '0;
   logic           as_n, wr_o, dir_tx, den_n;
   logic [BW-1:0]  be_o;
   logic           rdy_i = 1'b0;
   logic           lock_drv;
   logic           lock_busy = 1'b0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lbus_seq #(.DATA_W(DW), .MAX_WORDS(NW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_last(req_last), .req_be(req_be),
      .req_wdata(req_wdata), .req_err(req_err), .rd_valid(rd_valid), .rd_data(rd_data),
      .lad_out(lad_out), .lad_oe(lad_oe), .lad_in(lad_in), .as_n(as_n), .wr_o(wr_o),
      .dir_tx(dir_tx), .den_n(den_n), .be_o(be_o), .rdy_i(rdy_i),
      .lock_drv(lock_drv), .lock_busy(lock_busy)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic nxt();
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   task automatic t_reset();
      chk("R1 reset as_n", as_n, 1);
      chk("R5 reset den_n", den_n, 1);
      chk("R8 reset lock_drv", lock_drv, 0);
      chk("R11 reset req_ready", req_ready, 1);
      chk("R13 reset lad_oe", lad_oe, 0);
      chk("R9 reset be_o", be_o, 0);
   endtask

   task automatic t_read_wait();
      req_valid = 1; req_op = 2'd0; req_addr = 32'h1000_0040; req_last = 0;
      req_be = 16'h0006;
      nxt(); req_valid = 0;
      chk("R1 read addr as_n", as_n, 0);
      chk("R5 read addr den_n", den_n, 1);
      chk("R3 read wr_o", wr_o, 0);
      chk("R4 read dir_tx", dir_tx, 0);
      chk("R9 read addr be", be_o, 4'b0110);
      chk("R13 read addr lad", lad_out, 32'h1000_0040);
      chk("R13 read addr oe", lad_oe, 1);
      nxt();
      chk("R5 read data den_n", den_n, 0);
      chk("R1 read data as_n", as_n, 1);
      #1 chk("R12 no rd_valid w/o ready", rd_valid, 0);
      nxt();
      chk("R2 wait as_n", as_n, 1);
      chk("R2 wait den_n", den_n, 0);
      chk("R9 wait be", be_o, 4'b0110);
      chk("R13 read data oe", lad_oe, 0);
      rdy_i = 1; lad_in = 32'hDEAD_BEEF;
      #1;
      chk("R12 rd_valid", rd_valid, 1);
      chk("R12 rd_data", rd_data, 32'hDEAD_BEEF);
      chk("R11 final req_ready", req_ready, 1);
      nxt(); rdy_i = 0;
      chk("R11 idle after read", {as_n, den_n}, 2'b11);
   endtask

   task automatic t_burst_write();
      req_valid = 1; req_op = 2'd1; req_addr = 32'h0000_2000; req_last = 2;
      req_be = {4'h0, 4'b1100, 4'b0011, 4'b1111};
      req_wdata = {32'h0, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
      nxt(); req_valid = 0;
      chk("R9 burst addr be", be_o, 4'b1111);
      chk("R3 burst wr_o", wr_o, 1);
      chk("R4 burst dir_tx", dir_tx, 1);
      chk("R13 burst addr lad", lad_out, 32'h0000_2000);
      nxt();
      chk("R9 burst w0 be ahead", be_o, 4'b0011);
      chk("R13 burst w0 data", lad_out, 32'h1111_1111);
      chk("R13 burst w0 oe", lad_oe, 1);
      nxt();
      chk("R2 burst wait as_n", as_n, 1);
      chk("R9 burst wait be", be_o, 4'b0011);
      chk("R2 burst wait data held", lad_out, 32'h1111_1111);
      chk("R11 no ready mid-burst", req_ready, 0);
      rdy_i = 1;
      nxt();
      chk("R9 burst w1 be ahead", be_o, 4'b1100);
      chk("R13 burst w1 data", lad_out, 32'h2222_2222);
      nxt();
      chk("R9 burst last be", be_o, 4'b1100);
      chk("R13 burst w2 data", lad_out, 32'h3333_3333);
      chk("R3 burst wr held", wr_o, 1);
      #1 chk("R11 burst final ready", req_ready, 1);
      nxt(); rdy_i = 0;
      chk("R11 burst idle", {as_n, den_n}, 2'b11);
   endtask

   task automatic t_rmw_lock();
      lock_busy = 1;
      req_valid = 1; req_op = 2'd2; req_addr = 32'h0000_3004; req_last = 3;
      req_be = 16'h0001; req_wdata = {96'h0, 32'hCAFE_0001};
      nxt(); req_valid = 0;
      chk("R6 lock wait as_n", as_n, 1);
      chk("R6 lock wait lock_drv", lock_drv, 0);
      chk("R6 lock wait den_n", den_n, 1);
      nxt();
      chk("R6 still waiting", {as_n, lock_drv}, 2'b10);
      lock_busy = 0;
      nxt();
      chk("R7 read addr lock", lock_drv, 1);
      chk("R7 read addr as_n", as_n, 0);
      chk("R4 rmw read dir", dir_tx, 0);
      nxt();
      chk("R7 read data lock", lock_drv, 1);
      rdy_i = 1; lad_in = 32'h0000_00AA;
      #1 chk("R12 rmw rd_valid", rd_valid, 1);
      chk("R7 no accept between halves", req_ready, 0);
      nxt(); rdy_i = 0;
      chk("R7 write addr as_n", as_n, 0);
      chk("R7 write addr lock drop", lock_drv, 0);
      chk("R7 write wr_o", wr_o, 1);
      chk("R7 write same addr", lad_out, 32'h0000_3004);
      chk("R7 write be", be_o, 4'b0001);
      nxt();
      chk("R7 write data", lad_out, 32'hCAFE_0001);
      chk("R4 rmw write dir", dir_tx, 1);
      rdy_i = 1;
      nxt(); rdy_i = 0;
      chk("R7 single-word halves idle", {as_n, den_n}, 2'b11);
   endtask

   task automatic t_iack();
      req_valid = 1; req_op = 2'd3; req_addr = 32'h0; req_last = 2; req_be = 16'h000F;
      nxt(); req_valid = 0;
      chk("R8 iack addr lock", lock_drv, 1);
      chk("R4 iack dir", dir_tx, 0);
      nxt();
      chk("R8 iack data lock", lock_drv, 1);
      nxt();
      chk("R8 iack wait lock", lock_drv, 1);
      rdy_i = 1;
      nxt(); rdy_i = 0;
      chk("R8 iack lock released", lock_drv, 0);
      chk("R8 iack single word", den_n, 1);
   endtask

   task automatic t_illegal();
      req_valid = 1; req_op = 2'd0; req_last = 0; req_be = 16'h0005;
      nxt(); req_valid = 0;
      chk("R10 gap err", req_err, 1);
      chk("R10 gap no cycle", as_n, 1);
      nxt();
      chk("R10 err one cycle", req_err, 0);
      chk("R10 still idle", {as_n, den_n}, 2'b11);
      req_valid = 1; req_op = 2'd1; req_be = 16'h0000;
      nxt(); req_valid = 0;
      chk("R10 empty err", req_err, 1);
      nxt();
      req_valid = 1; req_op = 2'd0; req_last = 1; req_be = 16'h009F;
      nxt(); req_valid = 0;
      chk("R10 word1 gap err", req_err, 1);
      chk("R10 word1 gap no cycle", as_n, 1);
      nxt();
      req_valid = 1; req_op = 2'd0; req_last = 0; req_be = 16'h0058;
      nxt(); req_valid = 0;
      chk("R10 unused word ignored err", req_err, 0);
      chk("R10 unused word ignored start", as_n, 0);
      nxt(); rdy_i = 1;
      nxt(); rdy_i = 0;
   endtask

   task automatic t_back_to_back();
      req_valid = 1; req_op = 2'd1; req_addr = 32'h0000_4000; req_last = 0;
      req_be = 16'h000F; req_wdata = {96'h0, 32'h5555_AAAA};
      nxt(); req_valid = 0;
      nxt();
      rdy_i = 1;
      req_valid = 1; req_op = 2'd0; req_addr = 32'h0000_5008; req_be = 16'h0003;
      #1 chk("R11 ready in final state", req_ready, 1);
      nxt(); req_valid = 0; rdy_i = 0;
      chk("R11 direct address state", as_n, 0);
      chk("R11 new address", lad_out, 32'h0000_5008);
      chk("R4 dir turned in addr", dir_tx, 0);
      chk("R5 den off in addr", den_n, 1);
      nxt(); rdy_i = 1;
      nxt(); rdy_i = 0;
      chk("R11 back-to-back idle", {as_n, den_n}, 2'b11);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) nxt();
      rst_n = 1;
      nxt();
      t_reset();
      t_read_wait();
      t_burst_write();
      t_rmw_lock();
      t_iack();
      t_illegal();
      t_back_to_back();
      repeat (2) nxt();
      finish_run();
   end

endmodule